// File: doc/BRIEF.md
# Four-Channel Mode-Selectable Request Arbiter

This block picks one of four channel requests at a time and presents it as a one-hot grant together with a valid flag. A two-bit mode input chooses how the channels are ranked. At one extreme all four share a rotating (round-robin) turn. At the other extreme the order is completely fixed, with the lowest channel number highest. The two modes in between place one or two of the low channels at strict priority above a rotating group made of the remaining channels.

The grant is combinational from the request vector, the mode and a stored rotation pointer. A consumer pulses the accept strobe in the cycle it takes the granted channel. If that grant came from the rotating group, the pointer moves to the channel after the winner, so that channel has first claim on the next turn. Accepted grants to fixed-rank channels leave the pointer alone. The asynchronous active-low reset is released on the clock through a two-stage synchronizer.

The pointer is shared by all modes. When the mode makes the stored pointer fall below the rotating group, the search starts at the group's lowest channel.

Top module: `chan_arbiter`

## Requirements
- R1: `grant` has at most one bit set, and a set bit always belongs to a channel whose `req` bit is high (bit n of each vector is channel n).
- R2: `grant_valid` is high exactly when at least one `req` bit is high. With no request, `grant` is all zeros.
- R3: With `mode` = 2'b11 the winner is the lowest-numbered requesting channel.
- R4: With `mode` = 2'b10, channel 0 beats channel 1, and both beat channels 2 and 3. Channels 2 and 3 take turns.
- R5: With `mode` = 2'b01, channel 0 beats all others. Channels 1, 2 and 3 take turns.
- R6: With `mode` = 2'b00, all four channels take turns. The search starts at the pointer and wraps from 3 to 0.
- R7: When `accept` is high, a grant is valid and the winner is in the rotating group, the pointer becomes the next channel from the next cycle on. After channel 3 it wraps to the lowest channel of the group. Without such an accept the pointer holds.
- R8: An accepted grant to a fixed-rank channel leaves the pointer unchanged.
- R9: After reset the rotating search begins at the lowest channel of the group (channel 0 in mode 2'b00, channel 2 in mode 2'b10).
- R10: If the stored pointer lies below the rotating group of the current mode, the search starts at the group's lowest channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 4 | Per-channel request vector |
| mode | input | 2 | Ranking scheme select |
| accept | input | 1 | Grant consumed this cycle |
| grant | output | 4 | One-hot winning channel |
| grant_valid | output | 1 | A grant is present |

## Verification
`grant` and `grant_valid` follow `req` and `mode` in the same cycle with no register on the path. The bench therefore drives each input set on the falling edge and compares the outputs 5 ns later, before the next rising edge. The only register involved is the rotation pointer, which is written at the rising edge that follows an accepted grant and can first be seen in the next driven cycle. The bench's own pointer model is advanced at the sampling instant of the accepting cycle, so that the following comparison already uses the moved pointer. Reset release takes two rising edges because of the synchronizer, and the bench waits those edges out before its first check after reset.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  localparam int ARB_CH    = 4;
  localparam int ARB_IDX_W = $clog2(ARB_CH);

  // Mode codes: the value equals the number of fixed-rank low channels.
  typedef enum logic [1:0] {
    ARB_ALL_RR    = 2'b00,
    ARB_ONE_FIXED = 2'b01,
    ARB_TWO_FIXED = 2'b10,
    ARB_ALL_FIXED = 2'b11
  } arb_mode_e;
endpackage

// File: rtl/arb_rst_sync.sv
`timescale 1ns/1ps
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/arb_fixed_pick.sv
`timescale 1ns/1ps
module arb_fixed_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] gnt_o
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  // lowest set bit wins
  assign gnt_o = req_i & (~req_i + ONE);
endmodule

// File: rtl/arb_rr_pick.sv
`timescale 1ns/1ps
module arb_rr_pick #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [IDX_W-1:0]  ptr_i,
  output logic [NUM_CH-1:0] gnt_o
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  logic [NUM_CH-1:0] rot_req;
  logic [NUM_CH-1:0] rot_gnt;

  // rotate so that the pointer channel sits at position 0
  always_comb begin
    rot_req = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      rot_req[k] = req_i[ptr_i + IDX_W'(k)];
    end
  end

  assign rot_gnt = rot_req & (~rot_req + ONE);

  // rotate the winner back to its channel position
  always_comb begin
    gnt_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      gnt_o[ptr_i + IDX_W'(k)] = rot_gnt[k];
    end
  end
endmodule

// File: rtl/arb_rr_ptr.sv
`timescale 1ns/1ps
module arb_rr_ptr #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en_i,
  input  logic [IDX_W-1:0] gnt_idx_i,
  input  logic [IDX_W-1:0] grp_base_i,
  output logic [IDX_W-1:0] ptr_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_en_i) begin
      if (gnt_idx_i == LAST) ptr_d = grp_base_i;
      else                   ptr_d = gnt_idx_i + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (adv_en_i) ptr_q <= ptr_d;
  end

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en_i && (gnt_idx_i != LAST) |=> ptr_q == IDX_W'($past(gnt_idx_i) + IDX_W'(1)))
    else $error("pointer did not step past accepted winner");

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en_i && (gnt_idx_i == LAST) |=> ptr_q == $past(grp_base_i))
    else $error("pointer did not wrap to group base");

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en_i |=> $stable(ptr_q))
    else $error("pointer moved without an accepted rotating grant");
endmodule

// File: rtl/chan_arbiter.sv
`timescale 1ns/1ps
module chan_arbiter #(
  parameter int NUM_CH = arb_pkg::ARB_CH,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  mode,
  input  logic              accept,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid
);
  import arb_pkg::*;

  logic              rst_q_n;
  logic [NUM_CH-1:0] fixed_mask;
  logic [NUM_CH-1:0] fixed_req, rr_req;
  logic [NUM_CH-1:0] fixed_gnt, rr_gnt;
  logic              fixed_hit;
  logic [IDX_W-1:0]  rr_ptr, ptr_eff, gnt_idx;
  logic              adv_en;

  arb_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_q_n)
  );

  // the mode value is the count of fixed-rank low channels
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign fixed_mask[c] = (IDX_W'(c) < mode);
  end

  assign fixed_req = req & fixed_mask;
  assign rr_req    = req & ~fixed_mask;
  assign fixed_hit = |fixed_req;
  assign ptr_eff   = (rr_ptr < mode) ? mode : rr_ptr;

  arb_fixed_pick #(.NUM_CH(NUM_CH)) u_fixed (
    .req_i (fixed_req),
    .gnt_o (fixed_gnt)
  );

  arb_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rr (
    .req_i (rr_req),
    .ptr_i (ptr_eff),
    .gnt_o (rr_gnt)
  );

  assign grant       = fixed_hit ? fixed_gnt : rr_gnt;
  assign grant_valid = |req;

  always_comb begin
    gnt_idx = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) gnt_idx = gnt_idx | IDX_W'(c);
    end
  end

  assign adv_en = accept && grant_valid && !fixed_hit;

  arb_rr_ptr #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .adv_en_i   (adv_en),
    .gnt_idx_i  (gnt_idx),
    .grp_base_i (mode),
    .ptr_q      (rr_ptr)
  );

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(grant) && ((grant & ~req) == '0))
    else $error("grant not one-hot or not requested");

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req == '0) |-> (!grant_valid && (grant == '0)))
    else $error("grant present without request");

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    grant_valid |-> (grant != '0))
    else $error("valid without grant");

  assert_strict_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == IDX_W'(ARB_ALL_FIXED)) && req[1] && !req[0] |-> grant[1])
    else $error("strict order violated");

  assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == IDX_W'(ARB_TWO_FIXED)) && req[1] && !req[0] |-> grant[1])
    else $error("channel 1 lost to rotating pair");

  assert_top_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == IDX_W'(ARB_ONE_FIXED)) && req[0] |-> grant[0])
    else $error("channel 0 not on top");

  assert_fixed_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    accept && ((grant & fixed_mask) != '0) |=> $stable(rr_ptr))
    else $error("fixed grant moved pointer");
endmodule

// File: tb/sim_chan_arbiter.sv
`timescale 1ns/1ps
module sim_chan_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic [1:0] mode;
  logic       accept;
  logic [3:0] grant;
  logic       grant_valid;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] ref_ptr;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .accept(accept), .grant(grant), .grant_valid(grant_valid)
  );

  function automatic logic [3:0] model_gnt(logic [3:0] r, logic [1:0] m, logic [1:0] p);
    int f = int'(m);
    int s;
    for (int c = 0; c < f; c++) if (r[c]) return 4'(1 << c);
    s = (int'(p) < f) ? f : int'(p);
    for (int i = 0; i < 4; i++) begin
      int idx = (s + i) % 4;
      if (idx >= f && r[idx]) return 4'(1 << idx);
    end
    return 4'b0000;
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare 5 ns later, advance model
  task automatic cyc(logic [3:0] r, logic [1:0] m, logic a);
    logic [3:0] eg;
    string tag;
    @(negedge clk);
    req = r; mode = m; accept = a;
    #5;
    eg = model_gnt(r, m, ref_ptr);
    case (m)
      2'b00:   tag = "R6";
      2'b01:   tag = "R5";
      2'b10:   tag = "R4";
      default: tag = "R3";
    endcase
    chk(tag, grant, eg);
    chk("R2", {3'b000, grant_valid}, {3'b000, |r});
    if ($countones(grant) > 1 || (grant & ~r) != 4'b0000) chk("R1", grant, eg);
    if (a && r != 4'b0000) begin
      int gi = 0;
      for (int c = 0; c < 4; c++) if (eg[c]) gi = c;
      if (gi >= int'(m)) ref_ptr = (gi == 3) ? m : 2'(gi + 1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 4'b0000; mode = 2'b00; accept = 1'b0;
    ref_ptr = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; req = 4'b0000; mode = 2'b00; accept = 1'b0; ref_ptr = 2'b00;
    #5;
    chk("R2 reset idle", grant, 4'b0000);
    chk("R2 reset valid", {3'b000, grant_valid}, 4'b0000);
    do_reset();

    // R9: fresh pointer at lowest group channel
    cyc(4'b1111, 2'b00, 1'b0); chk("R9 mode00", grant, 4'b0001);
    cyc(4'b1100, 2'b10, 1'b0); chk("R9 mode10", grant, 4'b0100);

    // R7: full rotation with wrap in mode 00
    cyc(4'b1111, 2'b00, 1'b1); chk("R7 rot0", grant, 4'b0001);
    cyc(4'b1111, 2'b00, 1'b1); chk("R7 rot1", grant, 4'b0010);
    cyc(4'b1111, 2'b00, 1'b1); chk("R7 rot2", grant, 4'b0100);
    cyc(4'b1111, 2'b00, 1'b1); chk("R7 rot3", grant, 4'b1000);
    cyc(4'b1111, 2'b00, 1'b0); chk("R7 wrap", grant, 4'b0001);
    cyc(4'b1111, 2'b00, 1'b0); chk("R7 hold", grant, 4'b0001);

    // R8: accepted fixed grant leaves pointer where it was
    cyc(4'b0010, 2'b00, 1'b1);            // pointer -> 2
    cyc(4'b0011, 2'b10, 1'b1); chk("R8 fixed", grant, 4'b0001);
    cyc(4'b0010, 2'b10, 1'b1); chk("R8 fixed1", grant, 4'b0010);
    cyc(4'b1100, 2'b10, 1'b0); chk("R8 keep", grant, 4'b0100);

    // R7: wrap inside a pair group goes to channel 2
    cyc(4'b1000, 2'b10, 1'b1);
    cyc(4'b1110, 2'b01, 1'b0); chk("R7 wrap base", grant, 4'b0100);

    // R10: pointer below group is clamped to group base
    do_reset();
    cyc(4'b0001, 2'b00, 1'b1);            // pointer -> 1
    cyc(4'b1100, 2'b10, 1'b0); chk("R10 clamp", grant, 4'b0100);
    cyc(4'b1010, 2'b10, 1'b0); chk("R10 fixed first", grant, 4'b0010);
    cyc(4'b1000, 2'b11, 1'b0); chk("R3 last", grant, 4'b1000);
    cyc(4'b0000, 2'b01, 1'b1); chk("R2 none", grant, 4'b0000);

    // exhaustive request sweep for each mode and pointer position
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        do_reset();
        for (int s = 0; s < p; s++) cyc(4'(1 << s), 2'b00, 1'b1);
        for (int r = 0; r < 16; r++) cyc(4'(r), 2'(m), 1'b0);
      end
    end

    // long pseudo-random run with accepts and mode changes
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0], 2'((i / 97) % 4), lfsr[7] | lfsr[9]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule